// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one timer channel. A free-running count clock from elsewhere in the chip arrives asynchronously. It is synchronised into the system clock domain, and each rising edge becomes a single one-cycle advance pulse. The 16-bit counter (width `CNT_W`) steps once per pulse while the channel is enabled. The counter, the compare register, the compare output and the interrupt flag all live on the system clock.

When the counter equals the compare value at an advance pulse, that pulse is a match. A two-bit output select code decides what the match does to the compare output pin: drive it high, drive it low, toggle it, or leave it alone. The pin then keeps that level until software acts. Software re-arms an edge trigger by writing the opposite select code, which presets the pin to the starting level of the next edge. A separate clear-on-match bit decides whether the matching pulse zeroes the counter or lets it run on. Every match also sets a sticky interrupt flag, and software clears that flag with a write-one.

Software uses a small synchronous register port with four word addresses: control, compare, status and counter. Reads are combinational.

Top module: `tmr_match_top`

## Requirements
- R1: After reset the counter reads 0, the compare output is 0 and the interrupt is 0. When enabled, the counter rises by exactly one for each rising edge of `cnt_clk`, and reading address 3 returns its value.
- R2: With control bit 0 (enable) at 0, edges of `cnt_clk` leave the counter unchanged, and no match can occur.
- R3: With control bit 1 (clear-on-match) at 1, an advance pulse that finds the counter equal to the compare value loads the counter with 0 in place of incrementing it.
- R4: With clear-on-match at 0, a match does not disturb counting: the counter goes to compare+1. After all ones the counter wraps to 0.
- R5: Control bits [3:2] select the match action on `cmp_out`: 01 drives it to 1, 10 drives it to 0, 11 inverts it, and 00 leaves it unchanged.
- R6: After a match, `cmp_out` keeps its level. A control write that changes the select code presets `cmp_out` in the following cycle: a new code of 01 sets it to 0, and a new code of 10 sets it to 1. Rewriting the same code, or changing to 00 or 11, leaves it unchanged. A match in the same cycle takes priority over the preset.
- R7: Every match sets the sticky interrupt `irq`, visible as bit 0 at address 2. Writing 1 to that bit clears it. Writing 0 has no effect. A match in the same cycle as a clear leaves the flag set.
- R8: A `cnt_clk` held high for many system cycles produces exactly one advance, whatever the phase of `cnt_clk` relative to the system clock.
- R9: Address 0 reads back the control field (bits [3:0]), and address 1 reads back the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clk | input | 1 | Asynchronous count clock; each rising edge advances the counter |
| wr_en | input | 1 | Register write strobe, one cycle |
| addr | input | 2 | Register address: 0 control, 1 compare, 2 status, 3 counter |
| wdata | input | CNT_W | Register write data |
| rd_data | output | CNT_W | Combinational read data for `addr` |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Sticky match interrupt |

## Verification
The bench lines up a status-clear write with the exact cycle of a matching advance pulse. A design that gave the clear priority would lose that interrupt. It holds the count clock high for many cycles, where a level-sensitive design would run the counter away. It checks each select code, including a rewrite of the same code, since a design that presets on every control write would glitch the pin. It drives the counter through its all-ones wrap and through a clear-on-match, where an off-by-one compare would land on 1 or skip the zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP   = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd3;

    typedef enum logic [1:0] {
        SEL_HOLD = 2'b00,
        SEL_HIGH = 2'b01,
        SEL_LOW  = 2'b10,
        SEL_TOG  = 2'b11
    } out_sel_e;

    typedef struct packed {
        logic     en;
        logic     clr_on_match;
        out_sel_e sel;
    } ctrl_t;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sync[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            s_d.sync[i] = s_q.sync[i-1];
        end
        s_d.prev = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_pulse = s_q.sync[STAGES-1] & ~s_q.prev;

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              match,
    input  logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              irq,
    output logic              sel_chg,
    output out_sel_e          sel_new,
    output logic [CNT_W-1:0]  rd_data
);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cmp;
        logic             irq;
    } rs_t;

    rs_t r_d, r_q;
    logic wr_ctrl, wr_cmp, wr_stat;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_cmp  = wr_en && (addr == A_CMP);
    assign wr_stat = wr_en && (addr == A_STAT);

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.ctrl.en           = wdata[0];
            r_d.ctrl.clr_on_match = wdata[1];
            r_d.ctrl.sel          = out_sel_e'(wdata[3:2]);
        end
        if (wr_cmp) r_d.cmp = wdata;
        if (match)               r_d.irq = 1'b1;
        else if (wr_stat && wdata[0]) r_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl    = r_q.ctrl;
    assign cmp_val = r_q.cmp;
    assign irq     = r_q.irq;
    assign sel_new = out_sel_e'(wdata[3:2]);
    assign sel_chg = wr_ctrl && (wdata[3:2] != r_q.ctrl.sel);

    always_comb begin
        rd_data = '0;
        case (addr)
            A_CTRL:  rd_data[CTRL_W-1:0] = {r_q.ctrl.sel, r_q.ctrl.clr_on_match, r_q.ctrl.en};
            A_CMP:   rd_data = r_q.cmp;
            A_STAT:  rd_data[0] = r_q.irq;
            default: rd_data = count;
        endcase
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             sel_chg,
    input  out_sel_e         sel_new,
    output logic             match,
    output logic [CNT_W-1:0] count,
    output logic             out_lvl
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             out;
    } cs_t;

    cs_t c_d, c_q;
    logic adv;

    assign adv   = tick && ctrl.en;
    assign match = adv && (c_q.count == cmp_val);

    always_comb begin
        c_d = c_q;
        if (adv) begin
            if (match && ctrl.clr_on_match) c_d.count = '0;
            else                            c_d.count = c_q.count + ONE;
        end
        if (match) begin
            case (ctrl.sel)
                SEL_HIGH: c_d.out = 1'b1;
                SEL_LOW:  c_d.out = 1'b0;
                SEL_TOG:  c_d.out = ~c_q.out;
                default:  c_d.out = c_q.out;
            endcase
        end else if (sel_chg) begin
            case (sel_new)
                SEL_HIGH: c_d.out = 1'b0;
                SEL_LOW:  c_d.out = 1'b1;
                default:  c_d.out = c_q.out;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count   = c_q.count;
    assign out_lvl = c_q.out;

endmodule

// File: rtl/tmr_match_top.sv
module tmr_match_top
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rd_data,
    output logic              cmp_out,
    output logic              irq
);
    logic             tick;
    logic             match;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cmp_val;
    ctrl_t            ctrl;
    logic             sel_chg;
    out_sel_e         sel_new;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (cnt_clk),
        .rise_pulse (tick)
    );

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .match   (match),
        .count   (count),
        .ctrl    (ctrl),
        .cmp_val (cmp_val),
        .irq     (irq),
        .sel_chg (sel_chg),
        .sel_new (sel_new),
        .rd_data (rd_data)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ctrl    (ctrl),
        .cmp_val (cmp_val),
        .sel_chg (sel_chg),
        .sel_new (sel_new),
        .match   (match),
        .count   (count),
        .out_lvl (cmp_out)
    );

endmodule

// File: rtl/tmr_match_chk.sv
module tmr_match_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             en,
    input logic             clr_on_match,
    input logic [1:0]       sel,
    input logic             match,
    input logic [CNT_W-1:0] count,
    input logic             cmp_out,
    input logic             irq
);
    // R1 / R4: enabled advance without clearing steps by one (wrap included)
    a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && !(match && clr_on_match)) |=> (count == $past(count) + CNT_W'(1)));

    // R2: no enabled advance, counter holds
    a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && en) |=> $stable(count));

    // R3: clear-on-match zeroes the counter
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (match && clr_on_match) |=> (count == '0));

    // R5: select codes drive the pin on a match
    a_r5_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        (match && sel == 2'b01) |=> cmp_out);
    a_r5_set_low: assert property (@(posedge clk) disable iff (!rst_n)
        (match && sel == 2'b10) |=> !cmp_out);
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (match && sel == 2'b11) |=> (cmp_out != $past(cmp_out)));

    // R7: every match leaves the interrupt set
    a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> irq);

    // R8: an advance pulse lasts one system cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

bind tmr_match_top tmr_match_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .en           (ctrl.en),
    .clr_on_match (ctrl.clr_on_match),
    .sel          (ctrl.sel),
    .match        (match),
    .count        (count),
    .cmp_out      (cmp_out),
    .irq          (irq)
);

// File: tb/tmr_match_top_test.sv
`timescale 1ns/1ps
module tmr_match_top_test;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_clk = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       addr = 2'd0;
    logic [CNT_W-1:0] wdata = '0;
    logic [CNT_W-1:0] rd_data;
    logic             cmp_out;
    logic             irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    tmr_match_top #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data),
        .cmp_out(cmp_out), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk);
        addr = a;
        #1 d = int'(rd_data);
    endtask

    task automatic pulse();
        @(negedge clk);
        cnt_clk = 1'b1;
        repeat (4) @(negedge clk);
        cnt_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        rd(2'd3, v);
        check("R1 reset count", v, 0);
        check("R1 reset cmp_out", int'(cmp_out), 0);
        check("R1 reset irq", int'(irq), 0);
    endtask

    task automatic t_regs();
        int v;
        wr(2'd0, 5);           // en=1, sel=01
        wr(2'd1, 3);
        rd(2'd0, v); check("R9 ctrl readback", v, 5);
        rd(2'd1, v); check("R9 cmp readback", v, 3);
    endtask

    task automatic t_count_match();
        int v;
        repeat (3) pulse();
        rd(2'd3, v); check("R1 three edges", v, 3);
        check("R5 no match yet", int'(cmp_out), 0);
        pulse();
        rd(2'd3, v); check("R4 run past match", v, 4);
        check("R5 code01 drives high", int'(cmp_out), 1);
        check("R7 irq on match", int'(irq), 1);
    endtask

    task automatic t_hold_preset();
        pulse();
        check("R6 holds after match", int'(cmp_out), 1);
        wr(2'd0, 5);           // same code
        check("R6 same code no preset", int'(cmp_out), 1);
        wr(2'd0, 9);           // code 10 presets high
        check("R6 code10 preset high", int'(cmp_out), 1);
        wr(2'd0, 5);           // code 01 presets low
        check("R6 code01 preset low", int'(cmp_out), 0);
    endtask

    task automatic t_irq_clear();
        int v;
        wr(2'd2, 0);
        rd(2'd2, v); check("R7 write0 keeps irq", v, 1);
        wr(2'd2, 1);
        rd(2'd2, v); check("R7 write1 clears irq", v, 0);
    endtask

    task automatic t_freeze();
        int v0, v1;
        rd(2'd3, v0);
        wr(2'd0, 4);           // en=0, sel=01
        repeat (3) pulse();
        rd(2'd3, v1); check("R2 disabled freeze", v1, v0);
    endtask

    task automatic t_clear_on_match();
        int c, v;
        rd(2'd3, c);
        wr(2'd1, c + 2);
        wr(2'd0, 11);          // en, clr, sel=10 -> preset high
        check("R6 preset high before trigger", int'(cmp_out), 1);
        repeat (3) pulse();
        rd(2'd3, v); check("R3 cleared on match", v, 0);
        check("R5 code10 drives low", int'(cmp_out), 0);
        pulse();
        rd(2'd3, v); check("R3 counts from zero", v, 1);
    endtask

    task automatic t_toggle_hold();
        int v;
        wr(2'd1, 3);
        wr(2'd0, 13);          // en, sel=11
        repeat (3) pulse();    // 1->2->3, match at 3 -> 4
        rd(2'd3, v); check("R4 no clear with bit off", v, 4);
        check("R5 code11 toggles", int'(cmp_out), 1);
        wr(2'd2, 1);
        wr(2'd1, 4);
        wr(2'd0, 1);           // en, sel=00
        pulse();
        check("R5 code00 holds", int'(cmp_out), 1);
        check("R7 irq with code00", int'(irq), 1);
    endtask

    task automatic t_wrap();
        int v;
        wr(2'd1, 7);
        for (int i = 0; i < 251; i++) pulse();   // 5 -> 255 -> 0
        rd(2'd3, v); check("R4 wrap to zero", v, 0);
    endtask

    task automatic t_priority();
        int v;
        wr(2'd1, 0);
        wr(2'd2, 1);
        check("R7 cleared before race", int'(irq), 0);
        @(negedge clk);
        cnt_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd2; wdata = CNT_W'(1);
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 match beats clear", int'(irq), 1);
        repeat (20) @(posedge clk);
        #1.3;                  // edge off the system clock phase
        cnt_clk = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd3, v); check("R8 long high counts once", v, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_count_match();
        t_hold_preset();
        t_irq_clear();
        t_freeze();
        t_clear_on_match();
        t_toggle_hold();
        t_wrap();
        t_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule